// File: doc/BRIEF.md
# Vector Loop Element Sequencer

The sequencer turns one scalar-style operation into a hardware loop of element operations. A separate set-length command loads a vector length register. Each accepted descriptor then issues that many element operations, one per cycle at most, in ascending index order from element 0. A descriptor carries three operands: a destination and two sources. Each operand has a base register number and a flag that marks it as vector or scalar. A vector operand steps to the next register for each element. A scalar operand keeps its base register for the whole loop.

Element operations leave on a valid/ready handshake. Each carries the element index and the three computed register numbers. A one-cycle completion pulse follows acceptance of the last element. If a computed register number would go past the top of the register file, that element is withheld, an error pulse is raised and the loop is abandoned. Register numbers are 7 bits wide, for registers 0 to 127. The largest vector length is a parameter, with a default of 64.

Top module: `vec_elem_seq`

## Requirements
- R1: A set-length command loads the vector length register. The value is clamped to MAX_VL, which is 64 by default. The length stays in force for every later descriptor until the next set-length command.
- R2: A descriptor accepted with length N issues exactly N element operations. Their indices are 0, 1, ..., N-1 in that order, and each element is issued once.
- R3: For element i, an operand whose vector flag is 1 produces register base+i.
- R4: An operand whose vector flag is 0 produces its base register for every element of the loop.
- R5: The destination, first source and second source flags act independently. Any mix of vector and scalar operands is valid in one descriptor.
- R6: A descriptor accepted with length 0 issues no element, and done_o is high in the cycle that follows its acceptance.
- R7: If any operand of the current element computes a register number above 127, elem_valid_o stays low for that element. err_o is high for one cycle in the next cycle, no done pulse follows, and the sequencer returns to idle. Elements before that one are issued normally.
- R8: While elem_valid_o is high and elem_ready_i is low, elem_valid_o, the index and the three register numbers hold their values.
- R9: done_o is high for exactly the one cycle after the last element is accepted, and op_ready_o is high in that cycle. A descriptor offered in that cycle is accepted and starts a new loop.
- R10: op_ready_o is low while a loop is running. A descriptor offered then is ignored and does not alter the loop in progress.
- R11: A set-length command issued while a loop is running leaves that loop's element count unchanged and applies from the next descriptor.
- R12: After reset, op_ready_o is high and elem_valid_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setvl_valid_i | input | 1 | Set-length command strobe |
| setvl_len_i | input | LEN_W | Requested vector length |
| op_valid_i | input | 1 | Descriptor offered |
| op_ready_o | output | 1 | Sequencer idle and able to take a descriptor |
| rd_base_i | input | 7 | Destination base register |
| rd_vec_i | input | 1 | Destination is vector (1) or scalar (0) |
| ra_base_i | input | 7 | First source base register |
| ra_vec_i | input | 1 | First source is vector (1) or scalar (0) |
| rb_base_i | input | 7 | Second source base register |
| rb_vec_i | input | 1 | Second source is vector (1) or scalar (0) |
| elem_valid_o | output | 1 | Element operation valid |
| elem_ready_i | input | 1 | Downstream accepts the element |
| elem_idx_o | output | LEN_W | Element index |
| elem_rd_o | output | 7 | Destination register for this element |
| elem_ra_o | output | 7 | First source register for this element |
| elem_rb_o | output | 7 | Second source register for this element |
| done_o | output | 1 | Loop completion pulse |
| err_o | output | 1 | Register range error pulse |

## Verification
Two events can share one cycle. In the first, the completion pulse of one loop meets the acceptance of the next descriptor. The bench provokes this by offering a new descriptor in the very cycle done_o is observed high. It then judges that the second loop runs with its own bases and full length, and that the first loop issues no extra element. In the second, a set-length command and a rejected descriptor arrive while a loop is stalled. The bench judges that the stalled element holds its fields, that the running loop keeps its original bases and count, and that only the next descriptor uses the new length.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  parameter int unsigned REG_W = 7;
  localparam int unsigned NOPND = 3;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic             vec;
  } opnd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/vl_reg.sv
module vl_reg #(
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned LEN_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] vl_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_VL);

  logic [LEN_W-1:0] vl_q, vl_d;

  always_comb vl_d = (len_i > MAX_L) ? MAX_L : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vl_q <= '0;
    else if (set_i) vl_q <= vl_d;
  end

  assign vl_o = vl_q;

  // R1
  vl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= MAX_L);

  // R1
  vl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(vl_o));
endmodule

// File: rtl/opnd_unit.sv
module opnd_unit import vseq_pkg::*; #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  opnd_t            opnd_i,
  input  logic             run_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [REG_W-1:0] reg_o,
  output logic             ovf_o
);
  localparam int unsigned SUM_W = ((IDX_W > REG_W) ? IDX_W : REG_W) + 1;

  opnd_t            opnd_q;
  logic [SUM_W-1:0] sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     opnd_q <= '0;
    else if (load_i) opnd_q <= opnd_i;
  end

  // vector operands step with the element index
  always_comb begin
    sum = SUM_W'(opnd_q.base);
    if (opnd_q.vec) sum = sum + SUM_W'(idx_i);
  end

  assign reg_o = sum[REG_W-1:0];
  assign ovf_o = |sum[SUM_W-1:REG_W];

  // R4
  scalar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !opnd_q.vec && !$past(load_i) |-> $stable(reg_o));

  // R3
  vec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && opnd_q.vec |=> reg_o == REG_W'($past(reg_o) + 1'b1));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl import vseq_pkg::*; #(
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [LEN_W-1:0] vl_i,
  input  logic             any_ovf_i,
  input  logic             elem_ready_i,
  output logic             op_ready_o,
  output logic             load_o,
  output logic             run_o,
  output logic             adv_o,
  output logic [LEN_W-1:0] idx_o,
  output logic             elem_valid_o,
  output logic             done_o,
  output logic             err_o
);
  st_e              st_q;
  logic [LEN_W-1:0] idx_q, len_q;
  logic             done_q, err_q;
  logic             fire, last;

  assign op_ready_o   = (st_q == ST_IDLE);
  assign run_o        = (st_q == ST_RUN);
  assign load_o       = op_ready_o && op_valid_i;
  assign elem_valid_o = run_o && !any_ovf_i;
  assign fire         = elem_valid_o && elem_ready_i;
  assign last         = (idx_q == len_q - 1'b1);
  assign adv_o        = fire && !last;
  assign idx_o        = idx_q;
  assign done_o       = done_q;
  assign err_o        = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (op_valid_i) begin
            len_q <= vl_i;
            idx_q <= '0;
            if (vl_i == '0) done_q <= 1'b1;
            else            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (any_ovf_i) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (fire) begin
            if (last) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o && !elem_ready_i |=> elem_valid_o && $stable(idx_o));

  // R2
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> idx_o == LEN_W'($past(idx_o) + 1'b1));

  // R6
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && (vl_i == '0) |=> done_o && !elem_valid_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> op_ready_o && !err_o);

  // R7
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> op_ready_o && !elem_valid_o);

  // R10
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o |-> !op_ready_o);
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq import vseq_pkg::*; #(
  parameter  int unsigned MAX_VL = 64,
  localparam int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setvl_valid_i,
  input  logic [LEN_W-1:0] setvl_len_i,
  input  logic             op_valid_i,
  output logic             op_ready_o,
  input  logic [REG_W-1:0] rd_base_i,
  input  logic             rd_vec_i,
  input  logic [REG_W-1:0] ra_base_i,
  input  logic             ra_vec_i,
  input  logic [REG_W-1:0] rb_base_i,
  input  logic             rb_vec_i,
  output logic             elem_valid_o,
  input  logic             elem_ready_i,
  output logic [LEN_W-1:0] elem_idx_o,
  output logic [REG_W-1:0] elem_rd_o,
  output logic [REG_W-1:0] elem_ra_o,
  output logic [REG_W-1:0] elem_rb_o,
  output logic             done_o,
  output logic             err_o
);
  logic [LEN_W-1:0] vl;
  logic             load, run, adv;
  logic [LEN_W-1:0] idx;
  opnd_t            opnd_in [NOPND];
  logic [REG_W-1:0] regs    [NOPND];
  logic [NOPND-1:0] ovf;

  assign opnd_in[0] = '{base: rd_base_i, vec: rd_vec_i};
  assign opnd_in[1] = '{base: ra_base_i, vec: ra_vec_i};
  assign opnd_in[2] = '{base: rb_base_i, vec: rb_vec_i};

  vl_reg #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_vl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (setvl_valid_i),
    .len_i  (setvl_len_i),
    .vl_o   (vl)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    opnd_unit #(.IDX_W(LEN_W)) u_opnd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .opnd_i (opnd_in[g]),
      .run_i  (run),
      .adv_i  (adv),
      .idx_i  (idx),
      .reg_o  (regs[g]),
      .ovf_o  (ovf[g])
    );
  end

  seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_valid_i   (op_valid_i),
    .vl_i         (vl),
    .any_ovf_i    (|ovf),
    .elem_ready_i (elem_ready_i),
    .op_ready_o   (op_ready_o),
    .load_o       (load),
    .run_o        (run),
    .adv_o        (adv),
    .idx_o        (idx),
    .elem_valid_o (elem_valid_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  assign elem_idx_o = idx;
  assign elem_rd_o  = regs[0];
  assign elem_ra_o  = regs[1];
  assign elem_rb_o  = regs[2];
endmodule

// File: tb/sim_vec_elem_seq.sv
`timescale 1ns/1ps
module sim_vec_elem_seq;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          setvl_valid_i = 1'b0;
  logic [LW-1:0] setvl_len_i = '0;
  logic          op_valid_i = 1'b0;
  logic          op_ready_o;
  logic [6:0]    rd_base_i = '0, ra_base_i = '0, rb_base_i = '0;
  logic          rd_vec_i = 1'b0, ra_vec_i = 1'b0, rb_vec_i = 1'b0;
  logic          elem_valid_o;
  logic          elem_ready_i = 1'b0;
  logic [LW-1:0] elem_idx_o;
  logic [6:0]    elem_rd_o, elem_ra_o, elem_rb_o;
  logic          done_o, err_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  vec_elem_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .setvl_valid_i(setvl_valid_i), .setvl_len_i(setvl_len_i),
    .op_valid_i(op_valid_i), .op_ready_o(op_ready_o),
    .rd_base_i(rd_base_i), .rd_vec_i(rd_vec_i),
    .ra_base_i(ra_base_i), .ra_vec_i(ra_vec_i),
    .rb_base_i(rb_base_i), .rb_vec_i(rb_vec_i),
    .elem_valid_o(elem_valid_o), .elem_ready_i(elem_ready_i),
    .elem_idx_o(elem_idx_o), .elem_rd_o(elem_rd_o),
    .elem_ra_o(elem_ra_o), .elem_rb_o(elem_rb_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_len(input int n);
    setvl_valid_i = 1'b1;
    setvl_len_i   = LW'(n);
    @(negedge clk);
    setvl_valid_i = 1'b0;
  endtask

  // caller is at a negedge; returns at the negedge where done/err is seen
  task automatic run_op(input int rd, input int ra, input int rb,
                        input bit vd, input bit va, input bit vb,
                        input int n, input int stall, input int err_at,
                        input bit meddle, input string tag);
    int cnt = 0;
    int cyc = 0;
    bit fin = 0, got_done = 0, got_err = 0, stalled = 0;
    int s_idx = 0, s_rd = 0, s_ra = 0, s_rb = 0;
    int exp_n = (err_at >= 0) ? err_at : n;
    op_valid_i = 1'b1;
    rd_base_i = 7'(rd); ra_base_i = 7'(ra); rb_base_i = 7'(rb);
    rd_vec_i = vd; ra_vec_i = va; rb_vec_i = vb;
    chk(op_ready_o == 1'b1, {tag, " R9 accept"}, int'(op_ready_o), 1);
    @(negedge clk);
    op_valid_i = 1'b0;
    while (!fin && cyc < 1000) begin
      if (done_o) begin
        got_done = 1; fin = 1;
      end else if (err_o) begin
        got_err = 1; fin = 1;
      end else begin
        if (meddle && cyc == 1) begin
          op_valid_i = 1'b0;
          setvl_valid_i = 1'b0;
        end
        if (stalled)
          chk(elem_valid_o && int'(elem_idx_o) == s_idx && int'(elem_rd_o) == s_rd &&
              int'(elem_ra_o) == s_ra && int'(elem_rb_o) == s_rb,
              {tag, " R8 hold"}, int'(elem_idx_o), s_idx);
        elem_ready_i = (stall == 0) || (cyc % stall != 0);
        if (meddle && cyc == 0) begin
          // R10 R11: rejected descriptor and new length during a stalled loop
          elem_ready_i = 1'b0;
          op_valid_i = 1'b1;
          rd_base_i = 7'd90; ra_base_i = 7'd91; rb_base_i = 7'd92;
          setvl_valid_i = 1'b1;
          setvl_len_i = LW'(2);
          chk(op_ready_o == 1'b0, {tag, " R10 busy"}, int'(op_ready_o), 0);
        end
        if (elem_valid_o) begin
          if (elem_ready_i) begin
            chk(int'(elem_idx_o) == cnt, {tag, " R2 idx"}, int'(elem_idx_o), cnt);
            chk(int'(elem_rd_o) == (vd ? rd + cnt : rd), {tag, vd ? " R3 rd" : " R4 rd"},
                int'(elem_rd_o), vd ? rd + cnt : rd);
            chk(int'(elem_ra_o) == (va ? ra + cnt : ra), {tag, va ? " R3 ra" : " R4 ra"},
                int'(elem_ra_o), va ? ra + cnt : ra);
            chk(int'(elem_rb_o) == (vb ? rb + cnt : rb), {tag, vb ? " R3 rb" : " R4 rb"},
                int'(elem_rb_o), vb ? rb + cnt : rb);
            cnt++;
            stalled = 0;
          end else begin
            stalled = 1;
            s_idx = int'(elem_idx_o); s_rd = int'(elem_rd_o);
            s_ra = int'(elem_ra_o); s_rb = int'(elem_rb_o);
          end
        end
        @(negedge clk);
        cyc++;
      end
    end
    elem_ready_i = 1'b0;
    chk(cnt == exp_n, {tag, " R2 count"}, cnt, exp_n);
    chk(got_done == (err_at < 0), {tag, " R9 done"}, int'(got_done), int'(err_at < 0));
    chk(got_err == (err_at >= 0), {tag, " R7 err"}, int'(got_err), int'(err_at >= 0));
    chk(op_ready_o == 1'b1, {tag, " R9 idle"}, int'(op_ready_o), 1);
    if (n == 0) chk(cyc == 0 && !elem_valid_o, {tag, " R6 zero"}, cyc, 0);
  endtask

  task automatic pulse_gone(input string tag);
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R9 pulse"}, int'(done_o), 0);
    chk(err_o == 1'b0, {tag, " R7 pulse"}, int'(err_o), 0);
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic t_reset;
    chk(op_ready_o == 1'b1, "R12 op_ready", int'(op_ready_o), 1);
    chk(elem_valid_o == 1'b0, "R12 elem_valid", int'(elem_valid_o), 0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R12 done/err", int'(done_o | err_o), 0);
  endtask

  task automatic t_mixed;
    set_len(3);
    // R5: vector dest, vector src, scalar src
    run_op(3, 15, 12, 1, 1, 0, 3, 0, -1, 0, "mixed R5");
    pulse_gone("mixed");
  endtask

  task automatic t_stall;
    set_len(4);
    run_op(40, 7, 60, 0, 1, 1, 4, 3, -1, 0, "stall R8");
    pulse_gone("stall");
    // R1: length persists without a new command
    run_op(1, 2, 3, 1, 0, 0, 4, 2, -1, 0, "persist R1");
    pulse_gone("persist");
  endtask

  task automatic t_zero;
    set_len(0);
    run_op(5, 6, 7, 1, 1, 1, 0, 0, -1, 0, "zero R6");
    pulse_gone("zero");
  endtask

  task automatic t_clamp;
    set_len(100);
    // R1: clamped to 64
    run_op(8, 9, 10, 0, 0, 0, 64, 0, -1, 0, "clamp R1");
    pulse_gone("clamp");
  endtask

  task automatic t_ovf;
    set_len(5);
    // R7: rd 125..127 fine, element 3 would use 128
    run_op(125, 5, 0, 1, 0, 1, 5, 0, 3, 0, "ovf R7");
    pulse_gone("ovf");
    run_op(120, 5, 0, 1, 0, 1, 5, 0, -1, 0, "after ovf R7");
    pulse_gone("after ovf");
  endtask

  task automatic t_meddle;
    set_len(4);
    run_op(10, 20, 30, 1, 1, 1, 4, 0, -1, 1, "busy R10");
    pulse_gone("busy");
    // R11: new length applies only now
    run_op(50, 51, 52, 1, 0, 1, 2, 0, -1, 0, "newlen R11");
    pulse_gone("newlen");
  endtask

  task automatic t_b2b;
    set_len(3);
    run_op(0, 1, 2, 1, 1, 1, 3, 0, -1, 0, "b2b first R9");
    // offered in the done cycle
    run_op(100, 110, 120, 1, 0, 1, 3, 2, -1, 0, "b2b second R9");
    pulse_gone("b2b");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_stall();
    t_zero();
    t_clamp();
    t_ovf();
    t_meddle();
    t_b2b();
    finish_up();
  end

  initial begin
    #900000;
    total++;
    bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_up();
  end
endmodule